// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM with a 19-bit address and an 8-bit data bus. The host offers one word at a time on a valid/ready port. For each request the controller produces the whole pin sequence for that access: chip select, output enable and write enable (all active low), the address, and the write data with a separate enable for the tri-state data driver.

Every interval of the pin sequence is a parameter counted in clock cycles, rounded up from the memory's nanosecond limits. The defaults assume a 10 ns clock and a 45 ns device. A read holds the access window and then waits out the bus release time. A write is built from an address-setup phase, a write-enable pulse and a recovery phase. The data driver is enabled only late in the pulse and is dropped on the same edge that ends it. When no request is pending, chip select stays high and the memory rests in standby.

Top module: `asram_ctrl`

## Requirements
- R1: After reset and whenever the controller is idle, memCsN, memOeN and memWeN are 1, memDqOe is 0 and reqReady is 1.
- R2: On the cycle after a read request is accepted, memCsN and memOeN go to 0 with memWeN at 1 and memAddr equal to the request address. They stay so for RD_ACCESS cycles (default 5).
- R3: Read data on memDqIn is sampled on the clock edge that closes the access window. It appears on rdData with rdValid high for exactly one cycle, the cycle right after that window.
- R4: After a read, memCsN and memOeN stay 1 for RD_TURN cycles (default 2) before reqReady returns. memDqOe is never 1 while memOeN is 0, nor in the cycle right after memOeN rises.
- R5: A write first holds memCsN at 0, memWeN at 1 and the address valid for WR_SETUP cycles (default 1) before memWeN falls.
- R6: memWeN stays 0 for exactly WR_PULSE cycles (default 4). memOeN stays 1 for the whole write, and memAddr does not change while memWeN is 0.
- R7: memDqOe is 1 during the last WR_DATA cycles (default 3) of the write pulse, with memDqOut equal to the request data. It falls on the same edge on which memWeN rises.
- R8: After the pulse, memCsN is 1 and memAddr still holds the write address for WR_RECOVER cycles (default 1). reqReady then returns to 1.
- R9: reqReady is 0 from the edge that accepts a request until that cycle's recovery count ends. Changes to the request inputs during that time have no effect on the pins.
- R10: A byte written at an address is returned on rdData by a later read of that address, for all data values and for the lowest and highest address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Request address |
| reqWdata | input | 8 | Write data |
| rdValid | output | 1 | One-cycle pulse: rdData holds read data |
| rdData | output | 8 | Captured read data |
| memAddr | output | 19 | SRAM address pins |
| memCsN | output | 1 | SRAM chip select, active low |
| memOeN | output | 1 | SRAM output enable, active low |
| memWeN | output | 1 | SRAM write enable, active low |
| memDqOut | output | 8 | Data to drive onto the SRAM bus |
| memDqOe | output | 1 | Enable for the bus driver |
| memDqIn | input | 8 | Data sampled from the SRAM bus |

## Verification
A sequencer that stays in a phase too long or leaves it too early shows up as a pin trace whose lengths are wrong. In the same access, the write-enable width, the access window or the idle return of reqReady lands one or more cycles away from where it belongs. Within a cycle of the fault, a bad driver-enable decode appears as bus contention, visible as data driven while output enable is low, or as write data missing at the end of the pulse. A broken capture or address latch is seen only at the data level: the behavioural memory stores the wrong byte, or a read returns it. Such a fault shows up on the next read of that address.

// File: rtl/asram_ctrl_pkg.sv
package asram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_REC,
    ST_WR_SET,
    ST_WR_PUL,
    ST_WR_REC
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch request address and data
    logic capture;  // sample bus into read register
  } dpStrobe_t;

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_ctrl_pkg::*;
#(
  parameter int RD_ACCESS  = 5,
  parameter int RD_TURN    = 2,
  parameter int WR_SETUP   = 1,
  parameter int WR_PULSE   = 4,
  parameter int WR_DATA    = 3,
  parameter int WR_RECOVER = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  output logic      reqReady,
  output dpStrobe_t strobe,
  output logic      memCsN,
  output logic      memOeN,
  output logic      memWeN,
  output logic      memDqOe
);

  localparam int MAX_CNT = maxOf4(maxOf4(RD_ACCESS, RD_TURN, WR_SETUP, WR_PULSE), WR_RECOVER, 1, 1);
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  ctrlState_e       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (reqWrite) begin
              state <= ST_WR_SET;
              cnt   <= CNT_W'(WR_SETUP - 1);
            end else begin
              state <= ST_RD_ACC;
              cnt   <= CNT_W'(RD_ACCESS - 1);
            end
          end
        end
        default: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            case (state)
              ST_RD_ACC: begin state <= ST_RD_REC; cnt <= CNT_W'(RD_TURN - 1);    end
              ST_WR_SET: begin state <= ST_WR_PUL; cnt <= CNT_W'(WR_PULSE - 1);   end
              ST_WR_PUL: begin state <= ST_WR_REC; cnt <= CNT_W'(WR_RECOVER - 1); end
              default:   begin state <= ST_IDLE;   cnt <= '0;                      end
            endcase
          end
        end
      endcase
    end
  end

  always_comb begin
    reqReady       = (state == ST_IDLE);
    strobe.load    = (state == ST_IDLE) && reqValid;
    strobe.capture = (state == ST_RD_ACC) && (cnt == '0);
    memCsN  = !((state == ST_RD_ACC) || (state == ST_WR_SET) || (state == ST_WR_PUL));
    memOeN  = !(state == ST_RD_ACC);
    memWeN  = !(state == ST_WR_PUL);
    memDqOe = (state == ST_WR_PUL) && (cnt < CNT_W'(WR_DATA));
  end

  // width of the current write-enable low run, for the pulse check
  logic [CNT_W:0] weLowCnt;
  always_ff @(posedge clk) begin
    if (!rstN)        weLowCnt <= '0;
    else if (!memWeN) weLowCnt <= weLowCnt + 1'b1;
    else              weLowCnt <= '0;
  end

  initial begin
    assert (RD_ACCESS >= 1 && RD_TURN >= 1 && WR_SETUP >= 1 && WR_PULSE >= 1 && WR_RECOVER >= 1)
      else $error("timing counts must be at least one cycle");
    assert (WR_DATA >= 1 && WR_DATA <= WR_PULSE)
      else $error("data overlap must fit inside the write pulse");
  end

  p_standby_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCsN && memOeN && memWeN && !memDqOe));

  p_no_contention_r4: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (memOeN && $past(memOeN)));

  p_oe_high_in_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  p_pulse_width_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt == (CNT_W+1)'(WR_PULSE)));

  p_drive_off_at_we_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> !memDqOe);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/asram_ctrl_dp.sv
module asram_ctrl_dp
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdDataQ;
  logic              rdValidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      rdDataQ  <= '0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= strobe.capture;
      if (strobe.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strobe.capture) rdDataQ <= memDqIn;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;
  assign rdData   = rdDataQ;
  assign rdValid  = rdValidQ;

  p_rd_pulse_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int RD_ACCESS  = 5,
  parameter int RD_TURN    = 2,
  parameter int WR_SETUP   = 1,
  parameter int WR_PULSE   = 4,
  parameter int WR_DATA    = 3,
  parameter int WR_RECOVER = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  dpStrobe_t strobe;

  asram_ctrl_fsm #(
    .RD_ACCESS (RD_ACCESS),
    .RD_TURN   (RD_TURN),
    .WR_SETUP  (WR_SETUP),
    .WR_PULSE  (WR_PULSE),
    .WR_DATA   (WR_DATA),
    .WR_RECOVER(WR_RECOVER)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strobe  (strobe),
    .memCsN  (memCsN),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .memDqOe (memDqOe)
  );

  asram_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memDqIn (memDqIn),
    .memAddr (memAddr),
    .memDqOut(memDqOut),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

  p_addr_hold_in_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> $stable(memAddr));

  p_addr_hold_recover_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> $stable(memAddr));

endmodule

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RD_ACC = 5;
  localparam int RD_TRN = 2;
  localparam int WR_SET = 1;
  localparam int WR_PUL = 4;
  localparam int WR_DAT = 3;
  localparam int WR_REC = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        rdValid;
  logic [7:0]  rdData;
  logic [18:0] memAddr;
  logic        memCsN, memOeN, memWeN, memDqOe;
  logic [7:0]  memDqOut;
  logic [7:0]  memDqIn;

  int vecCount = 0;
  int missCount = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_ctrl u_asram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // behavioural memory sampled once per cycle, plus shadow reference
  logic [7:0] sramArr [logic [18:0]];
  logic [7:0] refArr  [logic [18:0]];

  function automatic logic [7:0] peekArr(input logic [18:0] a);
    if (sramArr.exists(a)) return sramArr[a];
    return 8'h00;
  endfunction

  function automatic logic [7:0] refRead(input logic [18:0] a);
    if (refArr.exists(a)) return refArr[a];
    return 8'h00;
  endfunction

  assign memDqIn = (!memCsN && !memOeN && memWeN) ? peekArr(memAddr) : 8'h00;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  logic       prevWrite = 1'b0;
  logic [7:0] prevData  = '0;
  logic       prevDrv   = 1'b0;
  logic       prevOeN   = 1'b1;
  always @(negedge clk) begin
    if (rstN) begin
      if (memDqOe && (!memOeN || !prevOeN))
        chk(1'b0, "R4 bus contention", {31'd0, memOeN}, 32'd1);
      if (prevWrite && !(!memCsN && !memWeN)) begin
        chk(prevDrv, "R7 data driven at end of write", {31'd0, prevDrv}, 32'd1);
        sramArr[memAddr] = prevData;
      end
    end
    prevWrite = !memCsN && !memWeN;
    prevData  = memDqOut;
    prevDrv   = memDqOe;
    prevOeN   = memOeN;
  end

  // expected pins {csN, oeN, weN, dqOe} at cycle k after acceptance
  function automatic logic [3:0] expPins(input bit isWr, input int k);
    if (!isWr) begin
      if (k <= RD_ACC) return 4'b0010;
      return 4'b1110;
    end
    if (k <= WR_SET) return 4'b0110;
    if (k <= WR_SET + WR_PUL) return {3'b010, (k > WR_SET + WR_PUL - WR_DAT)};
    return 4'b1110;
  endfunction

  task automatic doTxn(input bit isWr, input logic [18:0] a, input logic [7:0] d);
    int total;
    logic [7:0] expRd;
    total = isWr ? (WR_SET + WR_PUL + WR_REC) : (RD_ACC + RD_TRN);
    expRd = refRead(a);
    reqValid = 1'b1; reqWrite = isWr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqWrite = $urandom() % 2 == 0;
    reqAddr  = 19'($urandom());
    reqWdata = 8'($urandom());
    if (isWr) refArr[a] = d;
    for (int k = 1; k <= total; k++) begin
      logic [3:0] e;
      e = expPins(isWr, k);
      chk({memCsN, memOeN, memWeN, memDqOe} == e,
          isWr ? "R5 R6 R7 R8 write pins" : "R2 R4 read pins",
          {28'd0, memCsN, memOeN, memWeN, memDqOe}, {28'd0, e});
      chk(!reqReady, "R9 ready low while busy", {31'd0, reqReady}, 32'd0);
      if (!memCsN || (isWr && k > WR_SET + WR_PUL))
        chk(memAddr == a, isWr ? "R6 R8 write address" : "R2 read address",
            {13'd0, memAddr}, {13'd0, a});
      if (memDqOe)
        chk(memDqOut == d, "R7 write data", {24'd0, memDqOut}, {24'd0, d});
      if (!isWr && k == RD_ACC + 1)
        chk(rdValid && rdData == expRd, "R3 R10 read data",
            {23'd0, rdValid, rdData}, {23'd1, expRd});
      else
        chk(!rdValid, "R3 rdValid single pulse", {31'd0, rdValid}, 32'd0);
      @(negedge clk);
    end
    chk(reqReady && memCsN && memOeN && memWeN && !memDqOe, "R1 idle after access",
        {27'd0, reqReady, memCsN, memOeN, memWeN, memDqOe}, 32'b11110);
  endtask

  logic [18:0] pool [8];

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(memCsN && memOeN && memWeN && !memDqOe, "R1 pins during reset",
        {28'd0, memCsN, memOeN, memWeN, memDqOe}, 32'b1110);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && memCsN && !rdValid, "R1 reset state",
        {29'd0, reqReady, memCsN, rdValid}, 32'b110);
    repeat (4) @(negedge clk);
    chk(memCsN && memOeN && memWeN && !memDqOe, "R1 standby while idle",
        {28'd0, memCsN, memOeN, memWeN, memDqOe}, 32'b1110);

    // directed corners
    doTxn(1'b1, 19'h00000, 8'hFF);
    doTxn(1'b1, 19'h7FFFF, 8'h00);
    doTxn(1'b0, 19'h00000, 8'h00);
    doTxn(1'b0, 19'h7FFFF, 8'h00);
    doTxn(1'b1, 19'h2AAAA, 8'hA5);
    doTxn(1'b0, 19'h2AAAA, 8'h00);
    doTxn(1'b0, 19'h2AAAA, 8'h00);
    doTxn(1'b1, 19'h2AAAA, 8'h5A);
    doTxn(1'b1, 19'h2AAAA, 8'h3C);
    doTxn(1'b0, 19'h2AAAA, 8'h00);

    for (int i = 0; i < 8; i++) pool[i] = 19'($urandom());
    for (int n = 0; n < 250; n++) begin
      int gap;
      gap = $urandom() % 3;
      for (int g = 0; g < gap; g++) @(negedge clk);
      doTxn($urandom() % 2 == 1, pool[$urandom() % 8], 8'($urandom()));
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vecCount++;
      missCount++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

endmodule